// File: doc/BRIEF.md
# Receive Flow-Control Pause Request Generator

This block sits between a receive packet buffer and a transmit MAC. Each cycle it compares the buffer's fill level in bytes with a programmable high-water mark. When the level reaches that mark and transmit flow control is enabled, it raises a request for an XOFF (PAUSE) frame. The request stays up until the transmitter acknowledges it.

A second source of requests comes from two external level inputs. When external mode is enabled, a rising XOFF input produces exactly one XOFF request. After XOFF falls, a rising XON input produces one XON request. Another XOFF is accepted only after XON has been raised and lowered again, which gives hysteresis. Both external inputs pass through two-flop synchronizers before their edges are detected.

Configuration is held in one 32-bit register. Software writes it and reads it back through a simple port. Frame construction and negotiation are handled elsewhere.

Top module: `rx_pause_req_gen`

## Requirements
- R1: The configuration register resets to 0. A write keeps only bit 31 (external mode enable) and bits 15:3 (threshold), and stores 0 in every other bit. The stored value appears on `reg_rdata_o` in the cycle after the write edge.
- R2: The threshold in bytes equals the register value masked to bits 15:3, so it always has 8-byte granularity. The level condition is true when `fill_level_i` is greater than or equal to that threshold.
- R3: An XOFF request is raised one cycle after the level condition goes from false to true, provided `tx_fc_en_i` is 1. It is not raised again until the level condition has been false for at least one cycle. Coming out of reset, the condition counts as already met.
- R4: While `tx_fc_en_i` is 0, neither threshold crossings nor external inputs raise any request.
- R5: External inputs are synchronized through two flops, so `xoff_req_o` rises after the third rising clock edge that follows a rising `ext_xoff_i`.
- R6: In external mode, one rising edge of `ext_xoff_i` gives exactly one XOFF request. Further XOFF rises are ignored until `ext_xon_i` has been asserted and then deasserted after XOFF fell.
- R7: A rising edge of `ext_xon_i` while `ext_xoff_i` is low, after an external XOFF, raises one XON request, but only if `xon_en_i` is 1. Without `xon_en_i`, the edge still re-arms the handshake. An XON edge while XOFF is still high is ignored.
- R8: With register bit 31 at 0, the external inputs raise no requests.
- R9: Each request stays asserted until its acknowledge is 1 at a clock edge, and drops in the following cycle.
- R10: XOFF has priority over XON. While an XOFF request is pending, `xon_req_o` stays low, and a pending XON appears only after the XOFF is acknowledged.
- R11: A threshold XOFF and an external XOFF that arrive on the same edge merge into a single XOFF request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_wdata_i | input | 32 | Configuration write data |
| reg_rdata_o | output | 32 | Configuration read data |
| fill_level_i | input | LVL_W | Receive buffer fill level in bytes |
| tx_fc_en_i | input | 1 | Transmit flow control enable |
| xon_en_i | input | 1 | XON frame enable |
| ext_xoff_i | input | 1 | External XOFF level (asynchronous) |
| ext_xon_i | input | 1 | External XON level (asynchronous) |
| xoff_req_o | output | 1 | XOFF frame request |
| xoff_ack_i | input | 1 | XOFF request acknowledge |
| xon_req_o | output | 1 | XON frame request |
| xon_ack_i | input | 1 | XON request acknowledge |

## Verification
Two cases put events into the same cycle. In the first, the fill level is raised to the threshold on the same edge at which a synchronized external XON edge is detected. The bench then expects only `xoff_req_o`, and expects XON to appear once XOFF has been acknowledged. In the second, a threshold crossing and a synchronized external XOFF edge are timed to coincide. The bench judges this case by showing that a single acknowledge leaves no second XOFF request behind.

// File: rtl/rx_pause_pkg.sv
package rx_pause_pkg;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned EXT_BIT = 31;
  localparam int unsigned THR_MSB = 15;
  localparam int unsigned THR_LSB = 3;
  localparam logic [CFG_W-1:0] CFG_MASK = 32'h8000_FFF8;

  typedef enum logic [1:0] {
    EXT_ARMED,
    EXT_XOFF_HI,
    EXT_WAIT_XON,
    EXT_XON_HI
  } ext_state_e;
endpackage

// File: rtl/rx_pause_sync2.sv
module rx_pause_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rx_pause_cfg.sv
module rx_pause_cfg
  import rx_pause_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [CFG_W-1:0] reg_wdata_i,
  output logic [CFG_W-1:0] reg_rdata_o,
  output logic             ext_en_o,
  output logic [THR_MSB:0] thr_bytes_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (reg_we_i) cfg_q <= reg_wdata_i & CFG_MASK;
  end

  assign reg_rdata_o = cfg_q;
  assign ext_en_o    = cfg_q[EXT_BIT];
  assign thr_bytes_o = {cfg_q[THR_MSB:THR_LSB], {THR_LSB{1'b0}}};

  // R1
  cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == ($past(reg_wdata_i) & CFG_MASK));
endmodule

// File: rtl/rx_pause_thr.sv
module rx_pause_thr
  import rx_pause_pkg::*;
#(
  parameter int unsigned LVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fill_level_i,
  input  logic [THR_MSB:0] thr_bytes_i,
  input  logic             tx_fc_en_i,
  output logic             evt_o
);
  logic cond, cond_q;

  assign cond = fill_level_i >= LVL_W'(thr_bytes_i);

  // reset as "already met" so a zero threshold does not fire out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b1;
    else         cond_q <= cond;
  end

  assign evt_o = cond & ~cond_q & tx_fc_en_i;

  // R3
  once_per_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/rx_pause_ext.sv
module rx_pause_ext
  import rx_pause_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_en_i,
  input  logic tx_fc_en_i,
  input  logic xon_en_i,
  input  logic xoff_s_i,
  input  logic xon_s_i,
  output logic xoff_evt_o,
  output logic xon_evt_o
);
  ext_state_e state_q, state_d;
  logic xoff_d_q, xon_d_q;
  logic xoff_rise, xon_rise;

  assign xoff_rise = xoff_s_i & ~xoff_d_q;
  assign xon_rise  = xon_s_i & ~xon_d_q;

  always_comb begin
    state_d    = state_q;
    xoff_evt_o = 1'b0;
    xon_evt_o  = 1'b0;
    unique case (state_q)
      EXT_ARMED: if (xoff_rise && ext_en_i && tx_fc_en_i) begin
        xoff_evt_o = 1'b1;
        state_d    = EXT_XOFF_HI;
      end
      EXT_XOFF_HI:  if (!xoff_s_i) state_d = EXT_WAIT_XON;
      EXT_WAIT_XON: if (xon_rise) begin
        xon_evt_o = ext_en_i & tx_fc_en_i & xon_en_i;
        state_d   = EXT_XON_HI;
      end
      EXT_XON_HI:   if (!xon_s_i) state_d = EXT_ARMED;
      default:      state_d = EXT_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= EXT_ARMED;
      xoff_d_q <= 1'b0;
      xon_d_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      xoff_d_q <= xoff_s_i;
      xon_d_q  <= xon_s_i;
    end
  end

  // R6
  one_xoff_per_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xoff_evt_o |=> (state_q == EXT_XOFF_HI) && !xoff_evt_o);
endmodule

// File: rtl/rx_pause_req.sv
module rx_pause_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xoff_set_i,
  input  logic xon_set_i,
  input  logic xoff_ack_i,
  input  logic xon_ack_i,
  output logic xoff_req_o,
  output logic xon_req_o
);
  logic xoff_pend_q, xon_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xoff_pend_q <= 1'b0;
      xon_pend_q  <= 1'b0;
    end else begin
      if (xoff_set_i)      xoff_pend_q <= 1'b1;
      else if (xoff_ack_i) xoff_pend_q <= 1'b0;
      if (xon_set_i)                   xon_pend_q <= 1'b1;
      else if (xon_ack_i && xon_req_o) xon_pend_q <= 1'b0;
    end
  end

  assign xoff_req_o = xoff_pend_q;
  assign xon_req_o  = xon_pend_q & ~xoff_pend_q;

  // R9
  xoff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xoff_req_o && !xoff_ack_i |=> xoff_req_o);

  // R10
  xon_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xon_req_o && !xon_ack_i |=> xon_req_o || xoff_req_o);
endmodule

// File: rtl/rx_pause_req_gen.sv
module rx_pause_req_gen
  import rx_pause_pkg::*;
#(
  parameter int unsigned LVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [LVL_W-1:0] fill_level_i,
  input  logic             tx_fc_en_i,
  input  logic             xon_en_i,
  input  logic             ext_xoff_i,
  input  logic             ext_xon_i,
  output logic             xoff_req_o,
  input  logic             xoff_ack_i,
  output logic             xon_req_o,
  input  logic             xon_ack_i
);
  logic             ext_en;
  logic [THR_MSB:0] thr_bytes;
  logic [1:0]       ext_sync;
  logic             thr_evt, ext_xoff_evt, ext_xon_evt;

  rx_pause_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ext_en_o    (ext_en),
    .thr_bytes_o (thr_bytes)
  );

  rx_pause_thr #(.LVL_W(LVL_W)) u_thr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_level_i (fill_level_i),
    .thr_bytes_i  (thr_bytes),
    .tx_fc_en_i   (tx_fc_en_i),
    .evt_o        (thr_evt)
  );

  rx_pause_sync2 #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ext_xon_i, ext_xoff_i}),
    .q_o    (ext_sync)
  );

  rx_pause_ext u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_en_i   (ext_en),
    .tx_fc_en_i (tx_fc_en_i),
    .xon_en_i   (xon_en_i),
    .xoff_s_i   (ext_sync[0]),
    .xon_s_i    (ext_sync[1]),
    .xoff_evt_o (ext_xoff_evt),
    .xon_evt_o  (ext_xon_evt)
  );

  rx_pause_req u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xoff_set_i (thr_evt | ext_xoff_evt),
    .xon_set_i  (ext_xon_evt),
    .xoff_ack_i (xoff_ack_i),
    .xon_ack_i  (xon_ack_i),
    .xoff_req_o (xoff_req_o),
    .xon_req_o  (xon_req_o)
  );

  // R4
  no_req_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_fc_en_i && !xoff_req_o |=> !xoff_req_o);
endmodule

// File: tb/rx_pause_req_gen_tb_top.sv
module rx_pause_req_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] fill_level_i = '0;
  logic        tx_fc_en_i = 1'b0;
  logic        xon_en_i = 1'b0;
  logic        ext_xoff_i = 1'b0;
  logic        ext_xon_i = 1'b0;
  logic        xoff_req_o, xon_req_o;
  logic        xoff_ack_i = 1'b0;
  logic        xon_ack_i = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rx_pause_req_gen #(.LVL_W(16)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .fill_level_i(fill_level_i), .tx_fc_en_i(tx_fc_en_i), .xon_en_i(xon_en_i),
    .ext_xoff_i(ext_xoff_i), .ext_xon_i(ext_xon_i),
    .xoff_req_o(xoff_req_o), .xoff_ack_i(xoff_ack_i),
    .xon_req_o(xon_req_o), .xon_ack_i(xon_ack_i)
  );

  // {level, xoff ack, expected xoff_req}; threshold 256 bytes
  localparam logic [17:0] VEC [10] = '{
    {16'd100, 1'b0, 1'b0},
    {16'd255, 1'b0, 1'b0},
    {16'd256, 1'b0, 1'b1},
    {16'd300, 1'b0, 1'b1},
    {16'd300, 1'b1, 1'b0},
    {16'd400, 1'b0, 1'b0},
    {16'd200, 1'b0, 1'b0},
    {16'd256, 1'b0, 1'b1},
    {16'd256, 1'b1, 1'b0},
    {16'd0,   1'b0, 1'b0}
  };

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic ack_xoff();
    xoff_ack_i = 1'b1; step(); xoff_ack_i = 1'b0;
  endtask

  task automatic ack_xon();
    xon_ack_i = 1'b1; step(); xon_ack_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R1 reset rdata", reg_rdata_o, 32'h0);
    chk("R3 reset xoff", {31'b0, xoff_req_o}, 32'h0);
    chk("R10 reset xon", {31'b0, xon_req_o}, 32'h0);

    wr(32'hFFFF_FFFF);
    chk("R1 mask", reg_rdata_o, 32'h8000_FFF8);
    wr(32'h0000_0107);
    chk("R2 granularity", reg_rdata_o, 32'h0000_0100);
    tx_fc_en_i = 1'b1;
    step();

    // R3 R9 threshold table
    foreach (VEC[i]) begin
      fill_level_i = VEC[i][17:2];
      xoff_ack_i   = VEC[i][1];
      step();
      xoff_ack_i   = 1'b0;
      chk($sformatf("R3 vec%0d", i), {31'b0, xoff_req_o}, {31'b0, VEC[i][0]});
    end

    // R4 disabled transmit flow control
    tx_fc_en_i = 1'b0;
    fill_level_i = 16'd300; step();
    chk("R4 thr off", {31'b0, xoff_req_o}, 32'h0);
    fill_level_i = 16'd0; step();
    tx_fc_en_i = 1'b1;

    // external mode, threshold out of reach
    wr(32'h8000_FFF8);
    ext_xoff_i = 1'b1; step(2);
    chk("R5 sync early", {31'b0, xoff_req_o}, 32'h0);
    step();
    chk("R5 sync edge3", {31'b0, xoff_req_o}, 32'h1);
    ack_xoff();
    chk("R9 ack clears", {31'b0, xoff_req_o}, 32'h0);
    ext_xoff_i = 1'b0; step(3);
    ext_xoff_i = 1'b1; step(4);
    chk("R6 no rearm", {31'b0, xoff_req_o}, 32'h0);
    ext_xoff_i = 1'b0; step(3);

    xon_en_i = 1'b0;
    ext_xon_i = 1'b1; step(4);
    chk("R7 xon disabled", {31'b0, xon_req_o}, 32'h0);
    ext_xon_i = 1'b0; step(4);
    ext_xoff_i = 1'b1; step(4);
    chk("R6 rearmed", {31'b0, xoff_req_o}, 32'h1);
    ack_xoff();

    xon_en_i = 1'b1;
    ext_xon_i = 1'b1; step(4);
    chk("R7 xon during xoff", {31'b0, xon_req_o}, 32'h0);
    ext_xon_i = 1'b0; step(3);
    ext_xoff_i = 1'b0; step(3);
    ext_xon_i = 1'b1; step(2);
    chk("R7 xon early", {31'b0, xon_req_o}, 32'h0);
    step();
    chk("R7 xon req", {31'b0, xon_req_o}, 32'h1);
    ack_xon();
    chk("R9 xon ack", {31'b0, xon_req_o}, 32'h0);
    ext_xon_i = 1'b0; step(4);

    // R8 external mode off
    wr(32'h0000_FFF8);
    ext_xoff_i = 1'b1; step(4);
    chk("R8 ext off", {31'b0, xoff_req_o}, 32'h0);
    ext_xoff_i = 1'b0; step(3);

    // R10 threshold XOFF and external XON on one edge
    wr(32'h8000_0100);
    ext_xoff_i = 1'b1; step(4);
    ack_xoff();
    ext_xoff_i = 1'b0; step(3);
    ext_xon_i = 1'b1; step(2);
    fill_level_i = 16'd256; step();
    chk("R10 xoff first", {30'b0, xoff_req_o, xon_req_o}, 32'h2);
    ack_xoff();
    chk("R10 xon after", {30'b0, xoff_req_o, xon_req_o}, 32'h1);
    ack_xon();
    chk("R10 both clear", {30'b0, xoff_req_o, xon_req_o}, 32'h0);

    // R11 threshold and external XOFF merge
    ext_xon_i = 1'b0; fill_level_i = 16'd0; step(4);
    ext_xoff_i = 1'b1; step(2);
    fill_level_i = 16'd256; step();
    chk("R11 merged req", {31'b0, xoff_req_o}, 32'h1);
    ack_xoff();
    chk("R11 single ack", {31'b0, xoff_req_o}, 32'h0);
    step();
    chk("R11 no second", {31'b0, xoff_req_o}, 32'h0);
    ext_xoff_i = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule